// File: doc/BRIEF.md
# SPI Flash Preamble-Seeking Loader

This block is a serial-flash boot reader. On a start pulse it pulls chip select low and clocks out a slow read command with a zero address. It then throws away a fixed-length header of returned bits and scans the following bit stream for a 16-bit sync word, checking every bit position. If the word does not appear within a budget of serial clocks, the load stops with a timeout, which is what a blank flash produces.

After sync, the stream holds a 16-bit big-endian payload length, the payload bytes, and a 16-bit big-endian CRC. Payload bytes leave on a valid/ready port. The block folds each byte into a running CRC and compares the result with the trailer. The serial clock runs at a slow boot rate for the command. From the first data bit onward it runs at a faster user rate. The block stretches the serial clock whenever the consumer holds back a byte.

Top module: `spi_boot_loader`

## Requirements
- R1: Out of reset `cs_n` is high, `sck` is low, `out_valid` is low and none of `done`, `timeout`, `crc_error` is set; `sck` is low whenever `cs_n` is high.
- R2: After start, `cs_n` stays low for the whole transfer. The first 32 bits on `mosi`, sampled on rising `sck` (SPI mode 0, MSB first), are opcode 0x03 followed by a 24-bit address of zero. `mosi` is low after those bits.
- R3: The first SKIP_BITS (default 128) bits returned after the address are never searched, so a sync word placed inside them is not acted on.
- R4: The sync word 0xBDB3 is found at any bit alignment after the skipped header.
- R5: If the sync word has not completed within HUNT_LIMIT (default 16384) serial clocks after the header, the load ends with `timeout` alone set and no byte output.
- R6: Each payload byte appears on `out_data` with `out_valid`, in stream order, and the number of bytes equals the length field. While `out_ready` is low the byte and `out_valid` hold steady. The serial clock pauses rather than lose data.
- R7: The CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF, fed MSB first, no reflection, no final XOR, over the payload bytes only. A trailer equal to it sets `done`; any other value sets `crc_error`.
- R8: The `sck` half period is HALF_BOOT (default 4) system clocks during the command and HALF_USER (default 2) from the first returned bit on. The switch happens on the byte boundary at the end of the address.
- R9: At the end of a load, `cs_n` goes high and `sck` stops low. Exactly one of `done`, `timeout`, `crc_error` is held until the next start, which clears it.
- R10: A length field of zero leads straight to the trailer. No byte is output, and a trailer of 0xFFFF gives `done`.
- R11: A start pulse during a load is ignored and does not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (taken only when idle) |
| sck | output | 1 | Serial clock to flash |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Consumer accepts byte |
| done | output | 1 | Load finished with matching CRC |
| timeout | output | 1 | Sync word not found in budget |
| crc_error | output | 1 | CRC trailer mismatch |

## Verification
The sync search is tried with the word at bit offsets 0, 3 and 7 after the header. This separates a bit-wise search from a byte-aligned one. A flash image that carries a complete valid frame inside the header area, followed by a different frame after it, shows whether the header is really skipped. An all-ones image separates a timeout from a false sync. Good and corrupted trailers, a zero length, and a consumer that stalls for long stretches distinguish a correct CRC verdict and byte count from an off-by-one or a dropped byte. Measuring the `sck` high time early and late in the load tells the two clock rates apart.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_SKIP, PH_HUNT, PH_LEN, PH_PAY, PH_TAIL
  } phase_t;

  localparam logic [7:0]  READ_OP   = 8'h03;
  localparam logic [15:0] SYNC_WORD = 16'hBDB3;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam int          CMD_BITS  = 32;

  // One byte of CRC-16, data fed MSB first, bit-serial feedback form.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/sbl_sck_gen.sv
module sbl_sck_gen #(
  parameter int HALF_BOOT = 4,
  parameter int HALF_USER = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  input  logic use_user,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int MAXH = (HALF_BOOT > HALF_USER) ? HALF_BOOT : HALF_USER;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          sck_q;
  logic          advance;
  logic          edge_now;

  assign lim      = use_user ? CW'(HALF_USER - 1) : CW'(HALF_BOOT - 1);
  assign advance  = run && !(hold && !sck_q);
  assign edge_now = advance && (cnt == lim);
  assign rise     = edge_now && !sck_q;
  assign fall     = edge_now && sck_q;
  assign sck      = sck_q & run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (advance) begin
      if (cnt == lim) begin
        cnt   <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbl_sync_hunter.sv
module sbl_sync_hunter #(
  parameter int LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic din,
  output logic hit,
  output logic expired
);
  import sbl_pkg::*;
  localparam int CW = $clog2(LIMIT + 1);

  logic [15:0]   sr;
  logic [CW-1:0] cnt;
  logic [15:0]   window;
  logic          armed;

  assign window  = {sr[14:0], din};
  assign armed   = (cnt >= CW'(15));
  assign hit     = en && armed && (window == SYNC_WORD);
  assign expired = en && !hit && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      sr  <= '0;
      cnt <= '0;
    end else if (en) begin
      sr  <= window;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter int HALF_BOOT  = 4,
  parameter int HALF_USER  = 2,
  parameter int SKIP_BITS  = 128,
  parameter int HUNT_LIMIT = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       done,
  output logic       timeout,
  output logic       crc_error
);
  import sbl_pkg::*;
  localparam int CNTW = $clog2(SKIP_BITS + CMD_BITS + 1);

  phase_t      phase;
  logic [31:0] cmd_sr;
  logic [CNTW-1:0] cnt;
  logic [2:0]  bit_idx;
  logic [7:0]  bsr;
  logic        byte_sel;
  logic [7:0]  hi_q;
  logic [15:0] remain;
  logic [15:0] crc_q;
  logic        use_user;

  // named internal events
  logic        rise, fall, run, hold;
  logic        hunt_en, sync_hit, hunt_expired;
  logic        in_bytes, byte_done;
  logic [7:0]  new_byte;
  logic [15:0] pair_word;

  assign run       = (phase != PH_IDLE);
  assign cs_n      = !run;
  assign hold      = out_valid && !out_ready;
  assign mosi      = (phase == PH_CMD) && cmd_sr[31];
  assign hunt_en   = rise && (phase == PH_HUNT);
  assign in_bytes  = (phase == PH_LEN) || (phase == PH_PAY) || (phase == PH_TAIL);
  assign byte_done = rise && in_bytes && (bit_idx == 3'd7);
  assign new_byte  = {bsr[6:0], miso};
  assign pair_word = {hi_q, new_byte};

  sbl_sck_gen #(.HALF_BOOT(HALF_BOOT), .HALF_USER(HALF_USER)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .use_user(use_user),
    .sck(sck), .rise(rise), .fall(fall)
  );

  sbl_sync_hunter #(.LIMIT(HUNT_LIMIT)) u_hunt (
    .clk(clk), .rst_n(rst_n), .clear(phase != PH_HUNT), .en(hunt_en),
    .din(miso), .hit(sync_hit), .expired(hunt_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cmd_sr    <= '0;
      cnt       <= '0;
      bit_idx   <= '0;
      bsr       <= '0;
      byte_sel  <= 1'b0;
      hi_q      <= '0;
      remain    <= '0;
      crc_q     <= CRC_SEED;
      use_user  <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_CMD;
          cmd_sr    <= {READ_OP, 24'h000000};
          cnt       <= '0;
          use_user  <= 1'b0;
          done      <= 1'b0;
          timeout   <= 1'b0;
          crc_error <= 1'b0;
        end
        PH_CMD: begin
          if (fall) cmd_sr <= {cmd_sr[30:0], 1'b0};
          if (rise) begin
            if (cnt == CNTW'(CMD_BITS - 1)) begin
              phase    <= PH_SKIP;
              cnt      <= '0;
              use_user <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_SKIP: if (rise) begin
          if (cnt == CNTW'(SKIP_BITS - 1)) phase <= PH_HUNT;
          else cnt <= cnt + 1'b1;
        end
        PH_HUNT: begin
          if (sync_hit) begin
            phase    <= PH_LEN;
            bit_idx  <= '0;
            byte_sel <= 1'b0;
            crc_q    <= CRC_SEED;
          end else if (hunt_expired) begin
            timeout <= 1'b1;
            phase   <= PH_IDLE;
          end
        end
        PH_LEN, PH_PAY, PH_TAIL: begin
          if (rise) begin
            bsr     <= new_byte;
            bit_idx <= bit_idx + 1'b1;
          end
          if (byte_done) begin
            if (phase == PH_PAY) begin
              out_data  <= new_byte;
              out_valid <= 1'b1;
              crc_q     <= crc16_step(crc_q, new_byte);
              remain    <= remain - 1'b1;
              if (remain == 16'd1) begin
                phase    <= PH_TAIL;
                byte_sel <= 1'b0;
              end
            end else if (!byte_sel) begin
              hi_q     <= new_byte;
              byte_sel <= 1'b1;
            end else if (phase == PH_LEN) begin
              remain   <= pair_word;
              byte_sel <= 1'b0;
              phase    <= (pair_word == 16'd0) ? PH_TAIL : PH_PAY;
            end else begin
              if (pair_word == crc_q) done <= 1'b1;
              else crc_error <= 1'b1;
              phase <= PH_IDLE;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_boot_loader_chk.sv
module spi_boot_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic       use_user,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done,
  input logic       timeout,
  input logic       crc_error,
  input logic       hunt_expired
);
  p_sck_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_mosi_low_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && use_user) |-> !mosi);

  p_timeout_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(hunt_expired));

  p_byte_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_one_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, timeout, crc_error}) <= 1);

  p_status_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout || crc_error) |-> cs_n);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_crcerr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_error && !start) |=> crc_error);
endmodule

bind spi_boot_loader spi_boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sck(sck), .cs_n(cs_n),
  .mosi(mosi), .use_user(use_user), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .done(done),
  .timeout(timeout), .crc_error(crc_error), .hunt_expired(hunt_expired)
);

// File: tb/tb_spi_boot_loader.sv
module tb_spi_boot_loader;
  localparam int SKIP = 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, out_ready;
  logic miso = 1'b1;
  logic sck, cs_n, mosi, out_valid, done, timeout, crc_error;
  logic [7:0] out_data;

  spi_boot_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .timeout(timeout), .crc_error(crc_error)
  );

  int n_cmp = 0, n_bad = 0;
  bit stream_bits [0:2047];
  logic [7:0] exp_b [0:63];
  int exp_n;

  // flash model
  int rc = 0, idx = 0;
  logic [31:0] cmd_cap = '0;
  always @(sck or cs_n) begin
    if (cs_n) begin
      rc = 0; idx = 0;
    end else if (sck) begin
      if (rc < 32) cmd_cap = {cmd_cap[30:0], mosi};
      rc++;
    end else if (rc >= 32) begin
      miso = (idx < 2048) ? stream_bits[idx] : 1'b1;
      idx++;
    end
  end

  // consumer
  int ready_mode = 0, cyc = 0, ngot = 0;
  logic [7:0] got [0:63];
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = (cyc % 40) >= 30;
    endcase
    if (out_valid && out_ready && ngot < 64) begin
      got[ngot] = out_data;
      ngot++;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 195000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic put_bits(input int pos, input logic [15:0] v, input int n);
    for (int k = 0; k < n; k++) stream_bits[pos + k] = v[n - 1 - k];
  endtask

  task automatic blank();
    for (int i = 0; i < 2048; i++) stream_bits[i] = 1'b1;
  endtask

  // writes sync, length, payload, trailer at pos; returns next pos
  task automatic put_frame(input int pos, input int plen, input int seed, input bit bad,
                           input bit record, output int nxt);
    logic [15:0] c;
    logic [7:0] b;
    int p;
    p = pos;
    put_bits(p, 16'hBDB3, 16); p += 16;
    put_bits(p, 16'(plen), 16); p += 16;
    c = 16'hFFFF;
    for (int i = 0; i < plen; i++) begin
      b = 8'(seed + i * 29);
      if (record) exp_b[i] = b;
      put_bits(p, {8'h00, b}, 8); p += 8;
      c = ref_crc(c, b);
    end
    put_bits(p, bad ? (c ^ 16'h0100) : c, 16); p += 16;
    if (record) exp_n = plen;
    nxt = p;
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic finish_wait();
    wait (done || timeout || crc_error);
    @(negedge clk);
  endtask

  task automatic check_bytes(input string tag, input int base);
    check({tag, " byte count"}, ngot - base, exp_n);
    for (int i = 0; i < exp_n && base + i < 64; i++)
      check({tag, " byte"}, got[base + i], exp_b[i]);
  endtask

  task automatic check_end(input string tag, input logic d, input logic t, input logic e);
    check({tag, " R9 cs_n released"}, cs_n, 1'b1);
    check({tag, " R9 sck idle"}, sck, 1'b0);
    check({tag, " done"}, done, d);
    check({tag, " timeout"}, timeout, t);
    check({tag, " crc_error"}, crc_error, e);
  endtask

  task automatic t_reset();
    check("R1 cs_n", cs_n, 1'b1);
    check("R1 sck", sck, 1'b0);
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 status", {done, timeout, crc_error}, 3'b000);
  endtask

  task automatic t_aligned();
    int nx, base;
    blank(); put_frame(SKIP, 5, 8'h11, 1'b0, 1'b1, nx);
    ready_mode = 0; base = ngot;
    kick(); finish_wait();
    check("R2 command word", cmd_cap, 32'h03000000);
    check_bytes("R4 R6 offset0", base);
    check_end("R7 offset0", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_stall_busy_start();
    int nx, base;
    blank(); put_frame(SKIP + 3, 7, 8'h42, 1'b0, 1'b1, nx);
    ready_mode = 2; base = ngot;
    kick();
    wait (rc >= 200);
    kick(); // R11 start while busy
    finish_wait();
    check("R11 cs_n stayed low (command)", cmd_cap, 32'h03000000);
    check_bytes("R4 R6 R11 offset3 stalled", base);
    check_end("R11 offset3", 1'b1, 1'b0, 1'b0);
    ready_mode = 0;
  endtask

  task automatic t_bad_crc();
    int nx, base;
    blank(); put_frame(SKIP + 7, 3, 8'h9C, 1'b1, 1'b1, nx);
    ready_mode = 1; base = ngot;
    kick(); finish_wait();
    check_bytes("R4 R6 offset7", base);
    check_end("R7 bad trailer", 1'b0, 1'b0, 1'b1);
    ready_mode = 0;
  endtask

  task automatic t_zero_len();
    int nx, base;
    blank(); put_frame(SKIP + 5, 0, 0, 1'b0, 1'b1, nx);
    base = ngot;
    kick(); finish_wait();
    check("R10 no bytes", ngot - base, 0);
    check_end("R10 zero length", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_header_skip();
    int nx, base;
    blank();
    put_frame(8, 1, 8'h5A, 1'b0, 1'b0, nx);        // inside the header
    put_frame(SKIP + 2, 2, 8'hC3, 1'b0, 1'b1, nx);  // real frame
    base = ngot;
    kick(); finish_wait();
    check_bytes("R3 header frame ignored", base);
    check_end("R3", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_blank();
    int base;
    blank(); base = ngot;
    kick(); finish_wait();
    check("R5 no bytes", ngot - base, 0);
    check_end("R5 blank flash", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_restart_and_divider();
    int nx, n;
    blank(); put_frame(SKIP, 4, 8'h07, 1'b0, 1'b1, nx);
    kick();
    check("R9 start clears timeout", timeout, 1'b0);
    @(posedge sck);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (sck);
    check("R8 boot half period", n, 4);
    wait (rc >= 60);
    @(posedge sck);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (sck);
    check("R8 user half period", n, 2);
    finish_wait();
    check_end("R8 R9 restart", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b1;
    blank();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_stall_busy_start();
    t_bad_crc();
    t_zero_len();
    t_header_skip();
    t_blank();
    t_restart_and_divider();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule